// File: doc/BRIEF.md
# Serial Register Port with Pointer Auto-Increment

This block is a slave-side two-wire serial control port that gives a host write and read access to a small bank of 8-bit configuration registers. SCL and SDA are sampled in the system clock domain through synchronizers. The block pulls the data line low through an open-drain output enable. The rest of the chip reads every register in parallel from a flat output bus.

After a write address, the first data byte is taken as a pointer byte. Its top bit turns automatic pointer advance on or off, and its low seven bits select a register. Later data bytes are written to the selected register, or read from it after a repeated START with a read address. The pointer either steps forward after each byte or stays where it is.

A high-to-low edge on the shared address/select pin after reset switches the port permanently to the other serial mode. From then on the two-wire engine leaves the bus alone.

Top module: `ctl_port`

## Requirements
- R1: The port answers the 7-bit address whose upper six bits are 001100 and whose lowest bit is the synchronized level of `ad_cs_i`; an address byte's bit 0 is read/write, 0 meaning write. On a match it pulls SDA low for the ninth clock pulse. On any other address it acknowledges nothing and does not act until the next START.
- R2: In a write transfer, the first byte after the address sets the pointer. Bit 7 is the increment flag and bits 6:0 are the register index.
- R3: Each later byte of a write transfer is stored in the register at the pointer and is acknowledged.
- R4: With the increment flag set, the pointer steps by one after each data byte, written or read. From index NREG-1 or higher it wraps to 0.
- R5: With the increment flag clear, the pointer stays fixed, so repeated writes hit one register and repeated reads return one register.
- R6: After a read address, the port shifts out the register at the pointer, MSB first. It sends the next byte after a master acknowledge (SDA low on the ninth pulse) and stops sending after a master non-acknowledge.
- R7: An index of NREG or above reads as 0x00. A write to such an index is acknowledged but changes no register.
- R8: A repeated START restarts decoding at the address byte and keeps the pointer.
- R9: A START or STOP in the middle of a byte abandons it, and no register is written.
- R10: A falling edge on `ad_cs_i` after reset sets `spi_mode_o`, which stays set until reset. While it is set, the port never drives SDA and never writes a register.
- R11: After reset all registers are 0x00, `sda_oe_o` is 0 and `spi_mode_o` is 0.
- R12: `reg_flat_o[8*i+7:8*i]` always shows register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the pad |
| sda_i | input | 1 | Serial data level from the pad |
| ad_cs_i | input | 1 | Shared address-bit / select pin |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| spi_mode_o | output | 1 | Sticky other-mode select |
| reg_flat_o | output | NREG*8 | All registers, register i at bits 8*i+7:8*i |

## Verification
A corrupted pointer shows up as data landing in the wrong register on the very next written byte, or as a wrong byte being shifted out during the next read. The tests therefore run block writes and reads across the wrap point, and check every register after each transfer. A wrong engine state usually shows at the next ninth clock pulse, either as a missing acknowledge or as one that should not be there. A mid-byte abort that does not clear the bit count shifts every later byte by one or more bits, and this appears within one transfer.

// File: rtl/ctl_pkg.sv
`timescale 1ns/1ps
package ctl_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = BYTE_W - 1;

    typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_SKIP} st_e;
    typedef enum logic [1:0] {K_ADDR, K_MAP, K_DATA} kind_e;

    typedef struct packed {
        st_e               st;
        kind_e             kind;
        logic [BYTE_W-1:0] sh;
        logic [3:0]        cnt;
        logic              rw;
        logic              mack;
        logic [PTR_W-1:0]  ptr;
        logic              incr;
        logic              oe;
        logic              scl_p;
        logic              sda_p;
    } eng_s;

    typedef struct packed {
        logic ad_p;
        logic spi;
    } mode_s;
endpackage

// File: rtl/ctl_sync.sv
`timescale 1ns/1ps
module ctl_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d = {st_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/ctl_regbank.sv
`timescale 1ns/1ps
module ctl_regbank #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    parameter int IW   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IW-1:0]      idx,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    output logic [NREG*DW-1:0] flat
);
    logic [NREG-1:0][DW-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (we && idx == IW'(i)) mem_d[i] = wdata;
            if (idx == IW'(i))       rdata    = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign flat = mem_q;
endmodule

// File: rtl/ctl_engine.sv
`timescale 1ns/1ps
module ctl_engine
    import ctl_pkg::*;
#(
    parameter int         NREG    = 16,
    parameter logic [5:0] ADDR_HI = 6'b001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              ad_s,
    input  logic              spi,
    input  logic [BYTE_W-1:0] rdata,
    output logic              oe,
    output logic              we,
    output logic [PTR_W-1:0]  idx,
    output logic [BYTE_W-1:0] wdata
);
    eng_s r_d, r_q;
    logic rise, fall, start, stop;
    logic [PTR_W-1:0] ptr_nx;

    always_comb begin
        r_d      = r_q;
        we       = 1'b0;
        r_d.scl_p = scl_s;
        r_d.sda_p = sda_s;
        rise  = scl_s & ~r_q.scl_p;
        fall  = ~scl_s & r_q.scl_p;
        start = scl_s & r_q.scl_p & r_q.sda_p & ~sda_s;
        stop  = scl_s & r_q.scl_p & ~r_q.sda_p & sda_s;
        ptr_nx = (r_q.ptr >= PTR_W'(NREG - 1)) ? '0 : r_q.ptr + PTR_W'(1);

        if (spi) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (start) begin
            r_d.st   = ST_RX;
            r_d.kind = K_ADDR;
            r_d.cnt  = '0;
            r_d.oe   = 1'b0;
        end else if (stop) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else begin
            case (r_q.st)
                ST_RX: begin
                    if (rise && r_q.cnt < 4'd8) begin
                        r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (fall && r_q.cnt == 4'd8) begin
                        r_d.st = ST_ACK;
                        r_d.oe = 1'b1;
                        case (r_q.kind)
                            K_ADDR: begin
                                if (r_q.sh[BYTE_W-1:1] == {ADDR_HI, ad_s}) begin
                                    r_d.rw = r_q.sh[0];
                                end else begin
                                    r_d.st = ST_SKIP;
                                    r_d.oe = 1'b0;
                                end
                            end
                            K_MAP: begin
                                r_d.incr = r_q.sh[BYTE_W-1];
                                r_d.ptr  = r_q.sh[PTR_W-1:0];
                            end
                            default: begin
                                we = 1'b1;
                                if (r_q.incr) r_d.ptr = ptr_nx;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = '0;
                        if (r_q.kind == K_ADDR && r_q.rw) begin
                            r_d.st   = ST_TX;
                            r_d.kind = K_DATA;
                            r_d.sh   = rdata;
                            r_d.oe   = ~rdata[BYTE_W-1];
                        end else begin
                            r_d.st   = ST_RX;
                            r_d.kind = (r_q.kind == K_ADDR) ? K_MAP : K_DATA;
                        end
                    end
                end
                ST_TX: begin
                    if (fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.st = ST_RACK;
                            r_d.oe = 1'b0;
                            if (r_q.incr) r_d.ptr = ptr_nx;
                        end else begin
                            r_d.sh  = {r_q.sh[BYTE_W-2:0], 1'b0};
                            r_d.oe  = ~r_q.sh[BYTE_W-2];
                            r_d.cnt = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (rise) begin
                        r_d.mack = sda_s;
                    end else if (fall) begin
                        if (!r_q.mack) begin
                            r_d.st  = ST_TX;
                            r_d.sh  = rdata;
                            r_d.oe  = ~rdata[BYTE_W-1];
                            r_d.cnt = '0;
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.scl_p <= 1'b1;
            r_q.sda_p <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign oe    = r_q.oe;
    assign idx   = r_q.ptr;
    assign wdata = r_q.sh;
endmodule

// File: rtl/ctl_port.sv
`timescale 1ns/1ps
module ctl_port
    import ctl_pkg::*;
#(
    parameter int         NREG        = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] ADDR_HI     = 6'b001100
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    input  logic                   ad_cs_i,
    output logic                   sda_oe_o,
    output logic                   spi_mode_o,
    output logic [NREG*BYTE_W-1:0] reg_flat_o
);
    logic [2:0] syn;
    logic scl_s, sda_s, ad_s;
    logic we;
    logic [PTR_W-1:0] idx;
    logic [BYTE_W-1:0] wdata, rdata;
    mode_s mode_d, mode_q;

    // bit 0 clock, bit 1 data (idle high), bit 2 address pin (low so no false edge)
    ctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ad_cs_i, sda_i, scl_i}), .q(syn)
    );
    assign scl_s = syn[0];
    assign sda_s = syn[1];
    assign ad_s  = syn[2];

    always_comb begin
        mode_d      = mode_q;
        mode_d.ad_p = ad_s;
        mode_d.spi  = mode_q.spi | (mode_q.ad_p & ~ad_s);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    ctl_engine #(.NREG(NREG), .ADDR_HI(ADDR_HI)) u_eng (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .ad_s(ad_s),
        .spi(mode_q.spi), .rdata(rdata), .oe(sda_oe_o), .we(we), .idx(idx), .wdata(wdata)
    );

    ctl_regbank #(.NREG(NREG), .DW(BYTE_W), .IW(PTR_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .idx(idx), .wdata(wdata),
        .rdata(rdata), .flat(reg_flat_o)
    );

    assign spi_mode_o = mode_q.spi;
endmodule

// File: rtl/ctl_port_chk.sv
`timescale 1ns/1ps
module ctl_port_chk #(
    parameter int NREG = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sda_oe,
    input logic            spi,
    input logic            scl_s,
    input logic [NREG*8-1:0] regs
);
    // R3: a register changes only together with the acknowledge of its byte
    a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs) |-> sda_oe);

    // R1: the data line is only moved while the sampled clock is low
    a_r1_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !spi) |-> !scl_s);

    // R10: mode select is sticky
    a_r10_spi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        spi |=> spi);

    // R10: no drive once the other mode is settled
    a_r10_spi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (spi && $past(spi)) |-> !sda_oe);
endmodule

bind ctl_port ctl_port_chk #(.NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .spi(spi_mode_o),
    .scl_s(scl_s), .regs(reg_flat_o)
);

// File: tb/sim_ctl_port.sv
`timescale 1ns/1ps
module sim_ctl_port;
    localparam int NREG = 16;
    localparam int H    = 10;
    localparam logic [7:0] DEV_W = 8'h32, DEV_R = 8'h33, DEV_X = 8'h30;
    localparam int NV = 5;
    // {pointer byte, data byte, register index}
    localparam logic [23:0] VEC [NV] = '{24'h00A500, 24'h053C05, 24'h0FFF0F,
                                         24'h8A110A, 24'h078007};

    logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, ad = 1'b1;
    logic sda_oe, spi;
    logic [NREG*8-1:0] regs;
    wire  sda_bus = sda_m & ~sda_oe;
    int   errs = 0, checks = 0;
    bit   done = 1'b0;
    logic [7:0] model [NREG];

    always #4 clk = ~clk;

    ctl_port #(.NREG(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .ad_cs_i(ad),
        .sda_oe_o(sda_oe), .spi_mode_o(spi), .reg_flat_o(regs)
    );

    function automatic logic [7:0] rget(input int i);
        return regs[8*i +: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic check_all(input string req);
        bit ok = 1'b1;
        logic [7:0] a = '0, e = '0;
        for (int i = 0; i < NREG; i++)
            if (ok && rget(i) !== model[i]) begin ok = 1'b0; a = rget(i); e = model[i]; end
        chk(ok, req, a, e);
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H); scl_m = 1'b0; hold(H);
    endtask

    task automatic bstop();
        hold(2); sda_m = 1'b0; hold(H); scl_m = 1'b1; hold(H); sda_m = 1'b1; hold(H);
    endtask

    task automatic wbit(input logic b);
        hold(2); sda_m = b; hold(H); scl_m = 1'b1; hold(H); scl_m = 1'b0;
    endtask

    task automatic rbit(output logic b);
        hold(2); sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H/2);
        b = sda_bus; hold(H/2); scl_m = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = ~b;
    endtask

    task automatic rbyte(input bit nack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin rbit(b); v[i] = b; end
        wbit(nack);
    endtask

    initial begin
        bit a1, a2, a3, a4;
        logic [7:0] v0, v1, v2;
        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        hold(5); rst_n = 1'b1; hold(5);

        // R11 reset state
        chk(regs == '0, "R11 regs", regs[31:0], 0);
        chk(!spi, "R11 spi", spi, 0);
        chk(!sda_oe, "R11 oe", sda_oe, 0);

        // table: single-byte writes
        for (int v = 0; v < NV; v++) begin
            bstart(); wbyte(DEV_W, a1); wbyte(VEC[v][23:16], a2); wbyte(VEC[v][15:8], a3); bstop();
            chk(a1 && a2 && a3, "R1 R3 ack", {a1, a2, a3}, 3'b111);
            model[VEC[v][3:0]] = VEC[v][15:8];
            chk(rget(int'(VEC[v][3:0])) == VEC[v][15:8], "R2 R3 R12 write", rget(int'(VEC[v][3:0])), VEC[v][15:8]);
        end

        // R1 wrong address: no ack, nothing written
        bstart(); wbyte(DEV_X, a1); wbyte(8'h01, a2); wbyte(8'h99, a3); bstop();
        chk(!a1 && !a2 && !a3, "R1 nack", {a1, a2, a3}, 0);
        check_all("R1 no write");

        // R4 block write across the wrap
        bstart(); wbyte(DEV_W, a1); wbyte(8'h8E, a2); wbyte(8'h21, a3); wbyte(8'h22, a4); wbyte(8'h23, a4); bstop();
        model[14] = 8'h21; model[15] = 8'h22; model[0] = 8'h23;
        check_all("R4 block write wrap");

        // R5 fixed pointer on writes
        bstart(); wbyte(DEV_W, a1); wbyte(8'h03, a2); wbyte(8'h44, a3); wbyte(8'h55, a4); bstop();
        model[3] = 8'h55;
        check_all("R5 fixed write");

        // R6 R8 read with increment after repeated start
        bstart(); wbyte(DEV_W, a1); wbyte(8'h8E, a2); bstart(); wbyte(DEV_R, a3);
        rbyte(1'b0, v0); rbyte(1'b0, v1); rbyte(1'b1, v2); bstop();
        chk(a3, "R8 read addr ack", a3, 1);
        chk(v0 == model[14], "R6 read 0", v0, model[14]);
        chk(v1 == model[15], "R6 read 1", v1, model[15]);
        chk(v2 == model[0], "R4 read wrap", v2, model[0]);

        // R5 R6 fixed pointer on reads
        bstart(); wbyte(DEV_W, a1); wbyte(8'h05, a2); bstart(); wbyte(DEV_R, a3);
        rbyte(1'b0, v0); rbyte(1'b1, v1); bstop();
        chk(v0 == model[5], "R6 fixed read 0", v0, model[5]);
        chk(v1 == model[5], "R5 fixed read 1", v1, model[5]);

        // R7 unimplemented index
        bstart(); wbyte(DEV_W, a1); wbyte(8'h20, a2); wbyte(8'h77, a3); bstop();
        chk(a3, "R7 write acked", a3, 1);
        check_all("R7 write ignored");
        bstart(); wbyte(DEV_W, a1); wbyte(8'h20, a2); bstart(); wbyte(DEV_R, a3);
        rbyte(1'b1, v0); bstop();
        chk(v0 == 8'h00, "R7 read zero", v0, 0);

        // R9 stop mid-byte
        bstart(); wbyte(DEV_W, a1); wbyte(8'h02, a2);
        wbit(1'b1); wbit(1'b0); wbit(1'b1); wbit(1'b0); bstop();
        check_all("R9 stop abort");

        // R8 R9 start mid-byte then a full write
        bstart(); wbyte(DEV_W, a1); wbyte(8'h02, a2);
        wbit(1'b1); wbit(1'b1); wbit(1'b0);
        bstart(); wbyte(DEV_W, a1); wbyte(8'h06, a2); wbyte(8'h66, a3); bstop();
        model[6] = 8'h66;
        chk(a1 && a2 && a3, "R8 restart acks", {a1, a2, a3}, 3'b111);
        check_all("R9 start abort");

        // R10 falling edge on the address pin
        ad = 1'b0; hold(10);
        chk(spi, "R10 set", spi, 1);
        bstart(); wbyte(DEV_X, a1); wbyte(8'h02, a2); wbyte(8'hEE, a3); bstop();
        chk(!a1 && !a2 && !a3, "R10 bus ignored", {a1, a2, a3}, 0);
        check_all("R10 no write");
        ad = 1'b1; hold(10);
        chk(spi, "R10 sticky", spi, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL watchdog R11: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule